// File: doc/BRIEF.md
# Streaming Packet Header Deframer

This block sits on a 64-bit streaming input that carries framed packets, each opening with a single 64-bit header word. It reads the header and decides how many leading words to discard. A type code says whether a timestamp word follows the header, and a count field says how many metadata words come next. Only the payload beats are passed to the downstream stream port. The decoded header and the captured timestamp appear on a sideband bus that is flagged on the first payload beat.

The length field frames every data packet. The number of payload beats follows from the byte length, and the output last marker is raised on the beat where that length is used up. For each virtual channel the block records the next sequence number it expects, and it pulses a gap flag when a header does not match. Packets whose type is not one of the two data types are removed completely. Packets whose framing is impossible are reported as malformed, and the block treats the following beat as a fresh header.

The controller is a five-state machine. ST_HEAD takes header beats. ST_STAMP takes the timestamp word. ST_META skips metadata words. ST_BODY forwards payload. ST_FLUSH discards unsupported packets. Its transitions are:

- head_to_stamp: the header is good and the type is 7.
- head_to_meta: the header is good, the type is 6 and the count is nonzero.
- head_to_body: the header is good and no skipped words remain, but payload does.
- head_to_flush: the type is unsupported and the beat has no last marker.
- stamp_to_meta, stamp_to_body, meta_to_body: the skip phase ends in the next phase that still has words.
- any_to_head: the packet's length is used up, a framing error occurs, or a flushed packet ends.

Top module: `pkt_deframer`

## Requirements
- R1: The header word is laid out MSB first as follows:
  - channel [63:58]
  - end-of-burst [57]
  - end-of-vector [56]
  - type [55:53]
  - metadata count [52:48]
  - sequence [47:32]
  - byte length [31:16]
  - destination [15:0]

  These fields appear on the sb_* outputs in that order. sb_valid is high only together with the first forwarded payload beat of a packet, and the sideband fields stay constant for the whole payload.
- R2: A type 6 packet forwards every word after the header unchanged on m_tdata, and sb_ts reads zero.
- R3: In a type 7 packet, the word after the header is captured on sb_ts and is not forwarded.
- R4: The metadata words that the count field gives are taken after the header and the optional timestamp, and they produce no output beat.
- R5: A data packet spans ceil(length/8) input beats in total, counting header, timestamp and metadata. m_tlast is high on the final one. The next beat is a header whether or not s_tlast was set, and a packet whose length covers only its skipped words produces no output.
- R6: In ST_BODY, s_tready equals m_tready and m_tvalid equals s_tvalid. In every other state s_tready is 1 and m_tvalid is 0.
- R7: A packet with a type other than 6 or 7 produces one pkt_drop pulse and no output. Its beats are consumed up to and including the one with s_tlast.
- R8: Each channel keeps an expected sequence value equal to the last sequence seen plus one, wrapping from 0xFFFF to 0x0000. A data header that differs from it pulses seq_gap. The first data header on a channel after reset never does.
- R9: A data header whose length field is smaller than 8 × (1 + timestamp + metadata count) bytes, or whose beat carries s_tlast while more beats are due, pulses pkt_malformed. The next beat is then taken as a header.
- R10: If s_tlast arrives on a skipped or payload beat before the length is used up, pkt_malformed pulses. m_tlast is raised on that beat if it is a payload beat, and the next beat is taken as a header.
- R11: seq_gap, pkt_drop and pkt_malformed are single-cycle pulses. They rise in the cycle after the input beat that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 64 | Input stream data |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input packet end marker |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 64 | Payload data |
| m_tvalid | output | 1 | Payload beat valid |
| m_tlast | output | 1 | Last payload beat |
| m_tready | input | 1 | Downstream ready |
| sb_valid | output | 1 | Sideband valid, with first payload beat |
| sb_vc | output | 6 | Virtual channel |
| sb_eob | output | 1 | End-of-burst flag |
| sb_eov | output | 1 | End-of-vector flag |
| sb_type | output | 3 | Packet type code |
| sb_nmeta | output | 5 | Metadata word count |
| sb_seq | output | 16 | Sequence number |
| sb_len | output | 16 | Packet byte length |
| sb_dst | output | 16 | Destination endpoint |
| sb_ts | output | 64 | Timestamp, zero for type 6 |
| seq_gap | output | 1 | Sequence gap pulse |
| pkt_drop | output | 1 | Unsupported packet dropped pulse |
| pkt_malformed | output | 1 | Framing error pulse |

## Verification
The bench builds the block with its defaults: six channel bits, so 64 sequence slots, and 14-bit beat counters. At these values the metadata count, including its top values, and the 0xFFFF to 0x0000 sequence wrap can all be driven with short packets. It uses several channels at once, so the per-channel tracking can be shown to keep channels apart. A first pass runs with no stalls and covers the corner cases: partial final word, zero payload, missing s_tlast, early s_tlast, short length, and unsupported types. A second pass mixes input gaps with pseudo-random downstream stalls, so ready is seen passing straight through during payload.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

    localparam int WORD_W = 64;
    localparam int VC_W   = 6;
    localparam int SEQ_W  = 16;
    localparam int LEN_W  = 16;
    localparam int MD_W   = 5;
    localparam int BEAT_W = LEN_W - 2;

    localparam logic [2:0] TYPE_DATA    = 3'h6;
    localparam logic [2:0] TYPE_DATA_TS = 3'h7;

    typedef struct packed {
        logic [VC_W-1:0]  vc;
        logic             eob;
        logic             eov;
        logic [2:0]       ptype;
        logic [MD_W-1:0]  nmeta;
        logic [SEQ_W-1:0] seq;
        logic [LEN_W-1:0] len;
        logic [15:0]      dst;
    } pkt_hdr_t;

    typedef enum logic [2:0] {
        ST_HEAD,
        ST_STAMP,
        ST_META,
        ST_BODY,
        ST_FLUSH
    } dfr_state_t;

endpackage

// File: rtl/dfr_hdr_unpack.sv
module dfr_hdr_unpack
    import deframer_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output pkt_hdr_t          hdr,
    output logic              is_data,
    output logic              has_ts,
    output logic [BEAT_W-1:0] total_beats,
    output logic              too_short
);
    localparam int OVH_W = MD_W + 2;

    logic [LEN_W:0]   len_round;
    logic [OVH_W-1:0] ovh_beats;
    logic [OVH_W+2:0] ovh_bytes;

    always_comb begin
        hdr         = pkt_hdr_t'(word);
        has_ts      = (hdr.ptype == TYPE_DATA_TS);
        is_data     = (hdr.ptype == TYPE_DATA) || has_ts;
        len_round   = {1'b0, hdr.len} + (LEN_W+1)'(7);
        total_beats = len_round[LEN_W:3];
        ovh_beats   = OVH_W'(1) + OVH_W'(has_ts) + OVH_W'(hdr.nmeta);
        ovh_bytes   = {ovh_beats, 3'b000};
        too_short   = hdr.len < LEN_W'(ovh_bytes);
    end

endmodule

// File: rtl/dfr_seq_track.sv
module dfr_seq_track #(
    parameter int VC_W  = 6,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk,
    input  logic [VC_W-1:0]  vc,
    input  logic [SEQ_W-1:0] seq,
    output logic             gap
);
    localparam int NUM_VC = 1 << VC_W;

    logic [SEQ_W-1:0]  expect_q [NUM_VC];
    logic [NUM_VC-1:0] seen_q;
    logic              gap_q;

    always_ff @(posedge clk) begin
        if (chk) begin
            expect_q[vc] <= seq + SEQ_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            gap_q  <= 1'b0;
        end else begin
            gap_q <= chk && seen_q[vc] && (seq != expect_q[vc]);
            if (chk) begin
                seen_q[vc] <= 1'b1;
            end
        end
    end

    assign gap = gap_q;

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
    import deframer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [63:0]       m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              sb_valid,
    output logic [5:0]        sb_vc,
    output logic              sb_eob,
    output logic              sb_eov,
    output logic [2:0]        sb_type,
    output logic [4:0]        sb_nmeta,
    output logic [15:0]       sb_seq,
    output logic [15:0]       sb_len,
    output logic [15:0]       sb_dst,
    output logic [63:0]       sb_ts,
    output logic              seq_gap,
    output logic              pkt_drop,
    output logic              pkt_malformed
);
    dfr_state_t        state_q, state_d;
    pkt_hdr_t          hdr_in, hdr_q;
    logic              is_data, has_ts, too_short;
    logic [BEAT_W-1:0] total_beats;
    logic [BEAT_W-1:0] rem_q;
    logic [MD_W-1:0]   meta_q;
    logic [WORD_W-1:0] ts_q;
    logic              first_q;
    logic              drop_q, mal_q;
    logic              beat_ok, last_by_len, early_end, bad_hdr;
    logic              hdr_beat, hdr_good, chk_seq;

    dfr_hdr_unpack u_unpack (
        .word        (s_tdata),
        .hdr         (hdr_in),
        .is_data     (is_data),
        .has_ts      (has_ts),
        .total_beats (total_beats),
        .too_short   (too_short)
    );

    dfr_seq_track #(.VC_W(VC_W), .SEQ_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .chk   (chk_seq),
        .vc    (hdr_in.vc),
        .seq   (hdr_in.seq),
        .gap   (seq_gap)
    );

    always_comb begin
        beat_ok     = s_tvalid && s_tready;
        last_by_len = (rem_q == BEAT_W'(1));
        early_end   = s_tlast && !last_by_len;
        bad_hdr     = too_short || (s_tlast && (total_beats != BEAT_W'(1)));
        hdr_beat    = beat_ok && (state_q == ST_HEAD);
        hdr_good    = hdr_beat && is_data && !bad_hdr;
        chk_seq     = hdr_beat && is_data;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (beat_ok) begin
            unique case (state_q)
                ST_HEAD: begin
                    if (!is_data) begin
                        state_d = s_tlast ? ST_HEAD : ST_FLUSH;
                    end else if (bad_hdr) begin
                        state_d = ST_HEAD;
                    end else if (has_ts) begin
                        state_d = ST_STAMP;
                    end else if (hdr_in.nmeta != '0) begin
                        state_d = ST_META;
                    end else if (total_beats != BEAT_W'(1)) begin
                        state_d = ST_BODY;
                    end else begin
                        state_d = ST_HEAD;
                    end
                end
                ST_STAMP: begin
                    if (early_end || (last_by_len && meta_q == '0)) begin
                        state_d = ST_HEAD;
                    end else if (meta_q != '0) begin
                        state_d = ST_META;
                    end else begin
                        state_d = ST_BODY;
                    end
                end
                ST_META: begin
                    if (early_end) begin
                        state_d = ST_HEAD;
                    end else if (meta_q != MD_W'(1)) begin
                        state_d = ST_META;
                    end else begin
                        state_d = last_by_len ? ST_HEAD : ST_BODY;
                    end
                end
                ST_BODY: begin
                    state_d = (early_end || last_by_len) ? ST_HEAD : ST_BODY;
                end
                ST_FLUSH: begin
                    state_d = s_tlast ? ST_HEAD : ST_FLUSH;
                end
                default: state_d = ST_HEAD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // packet context and error pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            ts_q    <= '0;
            rem_q   <= '0;
            meta_q  <= '0;
            first_q <= 1'b0;
            drop_q  <= 1'b0;
            mal_q   <= 1'b0;
        end else begin
            drop_q <= hdr_beat && !is_data;
            mal_q  <= (hdr_beat && is_data && bad_hdr) ||
                      (beat_ok && early_end &&
                       (state_q inside {ST_STAMP, ST_META, ST_BODY}));
            if (hdr_good) begin
                hdr_q   <= hdr_in;
                ts_q    <= '0;
                first_q <= 1'b1;
                rem_q   <= total_beats - BEAT_W'(1);
                meta_q  <= hdr_in.nmeta;
            end else if (beat_ok && state_q inside {ST_STAMP, ST_META, ST_BODY}) begin
                rem_q <= rem_q - BEAT_W'(1);
                if (state_q == ST_STAMP) ts_q <= s_tdata;
                if (state_q == ST_META)  meta_q <= meta_q - MD_W'(1);
                if (state_q == ST_BODY)  first_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        s_tready      = (state_q == ST_BODY) ? m_tready : 1'b1;
        m_tvalid      = (state_q == ST_BODY) && s_tvalid;
        m_tdata       = s_tdata;
        m_tlast       = last_by_len || s_tlast;
        sb_valid      = m_tvalid && first_q;
        sb_vc         = hdr_q.vc;
        sb_eob        = hdr_q.eob;
        sb_eov        = hdr_q.eov;
        sb_type       = hdr_q.ptype;
        sb_nmeta      = hdr_q.nmeta;
        sb_seq        = hdr_q.seq;
        sb_len        = hdr_q.len;
        sb_dst        = hdr_q.dst;
        sb_ts         = ts_q;
        pkt_drop      = drop_q;
        pkt_malformed = mal_q;
    end

endmodule

// File: rtl/dfr_checks.sv
module dfr_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        m_tlast,
    input logic        sb_valid,
    input logic [5:0]  sb_vc,
    input logic [15:0] sb_seq,
    input logic        seq_gap,
    input logic        pkt_drop,
    input logic        pkt_malformed
);
    p_ready_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (s_tready == m_tready) && s_tvalid);

    p_sideband_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid |-> m_tvalid);

    p_sideband_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && !m_tlast) |=> ($stable(sb_seq) && $stable(sb_vc)));

    p_tlast_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);

    p_drop_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |-> (!seq_gap && !pkt_malformed));

    p_drop_after_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |-> $past(s_tvalid && s_tready && !m_tvalid));

    p_gap_after_header_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_gap |-> $past(s_tvalid && s_tready && !m_tvalid));

    p_mal_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_malformed |-> $past(s_tvalid && s_tready));

endmodule

bind pkt_deframer dfr_checks u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_tvalid      (s_tvalid),
    .s_tready      (s_tready),
    .m_tvalid      (m_tvalid),
    .m_tready      (m_tready),
    .m_tlast       (m_tlast),
    .sb_valid      (sb_valid),
    .sb_vc         (sb_vc),
    .sb_seq        (sb_seq),
    .seq_gap       (seq_gap),
    .pkt_drop      (pkt_drop),
    .pkt_malformed (pkt_malformed)
);

// File: tb/pkt_deframer_test.sv
module pkt_deframer_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [63:0] s_tdata;
    logic        s_tvalid, s_tlast, s_tready;
    logic [63:0] m_tdata;
    logic        m_tvalid, m_tlast, m_tready;
    logic        sb_valid, sb_eob, sb_eov;
    logic [5:0]  sb_vc;
    logic [2:0]  sb_type;
    logic [4:0]  sb_nmeta;
    logic [15:0] sb_seq, sb_len, sb_dst;
    logic [63:0] sb_ts;
    logic        seq_gap, pkt_drop, pkt_malformed;

    pkt_deframer uut (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct { logic [63:0] d; logic l; } beat_t;
    beat_t q[$];
    int word_ctr = 0;
    int exp_out = 0;
    int out_beats = 0, gaps = 0, drops = 0, mals = 0;
    bit hs = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int ph = 0;            // 0 head, 1 stamp, 2 meta, 3 body, 4 flush
    int rem = 0, mleft = 0;
    bit first = 0;
    logic [63:0] mh = '0, mts = '0;
    bit pgap = 0, pdrop = 0, pmal = 0;
    string maltag = "R9";
    int exp_seq[64];
    bit seen[64];

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_hdr(int vc, int typ, int nm, int seq, int len, bit eob);
        return {vc[5:0], eob, 1'b0, typ[2:0], nm[4:0], seq[15:0], len[15:0], 16'h0C00 + 16'(vc)};
    endfunction

    function automatic logic [63:0] nxt_word();
        word_ctr++;
        return {16'hA5A5, 48'(word_ctr * 7919)};
    endfunction

    task automatic push(logic [63:0] d, logic l);
        beat_t b;
        b.d = d; b.l = l;
        q.push_back(b);
    endtask

    // well-formed data packet; body given in bytes
    task automatic add_pkt(int vc, int typ, int nm, int seq, int body, bit endmark, bit eob);
        int ovh = 1 + ((typ == 7) ? 1 : 0) + nm;
        int len = ovh * 8 + body;
        int tb = (len + 7) / 8;
        push(mk_hdr(vc, typ, nm, seq, len, eob), endmark && tb == 1);
        for (int i = 1; i < tb; i++) push(nxt_word(), endmark && (i == tb - 1));
        exp_out += tb - ovh;
    endtask

    // cycle-by-cycle reference compare
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; rem = 0; mleft = 0; first = 0; mh = '0; mts = '0;
            pgap = 0; pdrop = 0; pmal = 0; hs = 0;
            for (int i = 0; i < 64; i++) begin seen[i] = 0; exp_seq[i] = 0; end
        end else begin
            bit e_rdy, e_mv, e_last, e_sbv;
            string vtag;
            e_rdy  = (ph == 3) ? m_tready : 1'b1;
            e_mv   = (ph == 3) && s_tvalid;
            e_last = (rem == 1) || s_tlast;
            e_sbv  = e_mv && first;
            vtag   = (ph == 1) ? "R3" : (ph == 2) ? "R4" : (ph == 4) ? "R7" : "R2";
            chk("R6", "s_tready", s_tready, e_rdy);
            chk(vtag, "m_tvalid", m_tvalid, e_mv);
            if (e_mv) begin
                chk("R2", "m_tdata", m_tdata, s_tdata);
                chk((s_tlast && rem != 1) ? "R10" : "R5", "m_tlast", m_tlast, e_last);
            end
            chk("R1", "sb_valid", sb_valid, e_sbv);
            if (e_sbv) begin
                chk("R1", "sideband fields",
                    {sb_vc, sb_eob, sb_eov, sb_type, sb_nmeta, sb_seq, sb_len, sb_dst}, mh);
                chk("R3", "sb_ts", sb_ts, mts);
            end
            chk("R8/R11", "seq_gap", seq_gap, pgap);
            chk("R7/R11", "pkt_drop", pkt_drop, pdrop);
            chk({maltag, "/R11"}, "pkt_malformed", pkt_malformed, pmal);
            gaps += seq_gap; drops += pkt_drop; mals += pkt_malformed;
            if (m_tvalid && m_tready) out_beats++;

            hs = s_tvalid && s_tready;
            pgap = 0; pdrop = 0; pmal = 0;
            if (hs) begin
                logic [63:0] w;
                w = s_tdata;
                if (ph == 0) begin
                    int typ, nm, sq, ln, vc, tb, ob;
                    vc = w[63:58]; typ = w[55:53]; nm = w[52:48]; sq = w[47:32]; ln = w[31:16];
                    if (typ != 6 && typ != 7) begin
                        pdrop = 1;
                        if (!s_tlast) ph = 4;
                    end else begin
                        if (seen[vc] && sq != exp_seq[vc]) pgap = 1;
                        seen[vc] = 1;
                        exp_seq[vc] = (sq + 1) % 65536;
                        tb = (ln + 7) / 8;
                        ob = 1 + ((typ == 7) ? 1 : 0) + nm;
                        if (ln < ob * 8 || (s_tlast && tb > 1)) begin
                            pmal = 1; maltag = "R9";
                        end else begin
                            mh = w; mts = '0; first = 1; rem = tb - 1; mleft = nm;
                            if (typ == 7) ph = 1;
                            else if (nm > 0) ph = 2;
                            else if (rem > 0) ph = 3;
                        end
                    end
                end else if (ph == 4) begin
                    if (s_tlast) ph = 0;
                end else begin
                    bit early;
                    early = s_tlast && rem != 1;
                    rem--;
                    if (ph == 1) mts = w;
                    if (ph == 2) mleft--;
                    if (ph == 3) first = 0;
                    if (early) begin
                        pmal = 1; maltag = "R10"; ph = 0;
                    end else if (ph == 1 || ph == 2) begin
                        ph = (mleft > 0) ? 2 : (rem > 0) ? 3 : 0;
                    end else begin
                        ph = (rem > 0) ? 3 : 0;
                    end
                end
            end
        end
    end

    task automatic drive(bit stalls);
        while (q.size() > 0 || s_tvalid) begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (s_tvalid && hs) s_tvalid = 1'b0;
            m_tready = stalls ? (lfsr[3] | lfsr[7]) : 1'b1;
            if (!s_tvalid && q.size() > 0 && (!stalls || lfsr[5] || lfsr[1])) begin
                beat_t b;
                b = q.pop_front();
                s_tdata = b.d; s_tlast = b.l; s_tvalid = 1'b1;
            end
        end
        @(posedge clk); #1; m_tready = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        rst_n = 1'b0; s_tvalid = 1'b0; s_tdata = '0; s_tlast = 1'b0; m_tready = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "reset s_tready", s_tready, 1);
        chk("R2", "reset m_tvalid", m_tvalid, 0);
        chk("R11", "reset pulses", {seq_gap, pkt_drop, pkt_malformed}, 0);

        // pass 1: corner cases, no stalls
        add_pkt(1, 6, 0, 5, 24, 1, 1);          // R2 plain data, first on channel
        add_pkt(1, 6, 0, 6, 20, 1, 0);          // R5 partial final word
        add_pkt(2, 7, 2, 100, 16, 1, 0);        // R3 R4 timestamp and metadata
        add_pkt(1, 6, 0, 9, 8, 1, 0);           // R8 gap (expected 7)
        push(mk_hdr(1, 4, 0, 0, 24, 0), 0);     // R7 control packet
        push(nxt_word(), 0); push(nxt_word(), 1);
        push(mk_hdr(1, 5, 0, 0, 8, 0), 1);      // R7 reserved type
        push(mk_hdr(2, 7, 3, 101, 16, 0), 1);   // R9 length too short
        push(mk_hdr(4, 6, 0, 0, 48, 0), 0);     // R10 early end after 3 body beats
        push(nxt_word(), 0); push(nxt_word(), 0); push(nxt_word(), 1);
        exp_out += 3;
        add_pkt(3, 6, 0, 16'hFFFF, 8, 1, 0);    // R8 wrap
        add_pkt(3, 6, 0, 0, 8, 1, 0);
        add_pkt(5, 7, 1, 7, 0, 1, 0);           // R5 zero payload
        add_pkt(6, 6, 0, 1, 16, 0, 0);          // R5 no s_tlast
        add_pkt(6, 6, 0, 2, 8, 1, 0);
        add_pkt(7, 6, 31, 3, 8, 1, 0);          // R4 maximum metadata count
        drive(0);

        // pass 2: stalls and input gaps
        for (int i = 0; i < 24; i++) begin
            add_pkt(8 + i % 3, (i % 2) ? 7 : 6, i % 4, i / 3, 8 * (1 + i % 5) - i % 3, 1, i % 2);
        end
        drive(1);

        chk("R8", "gap pulse count", gaps, 1);
        chk("R7", "drop pulse count", drops, 2);
        chk("R9/R10", "malformed pulse count", mals, 2);
        chk("R5", "forwarded beat total", out_beats, exp_out);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule